// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the 32-bit program counter of a small load/store processor and works out the address of the next instruction in each cycle. It decodes the fetched instruction word, looks at the two register operands read for that instruction, and picks one successor: the following word, a PC-relative conditional branch target, a region-local absolute jump target, or an address taken from a register. Branch distances count words. Absolute jumps keep the PC's top four bits, place the 26-bit target field below them and append two zero bits.

For a jump-and-link, the block also hands back the return address and raises a write enable aimed at register 31. A stall input freezes the counter for the cycle. Delay slots are not modelled: a taken transfer affects the very next PC.

Top module: `pc_steer`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) loads the PC with 0.
- R2: With stall high, the PC keeps its value at the next edge, whatever the instruction is.
- R3: An instruction that is not a control transfer, and a conditional branch that is not taken, advance the PC by 4 (modulo 2^32).
- R4: Opcode 1 (bits 31:26) branches when rs bit 31 is 1. rt is ignored.
- R5: Opcode 4 branches when rs equals rt. Opcode 5 branches when they differ.
- R6: A taken branch's target is PC+4 plus the sign-extended bits 15:0 shifted left by 2, modulo 2^32.
- R7: Opcodes 2 and 3 load the PC with {PC[31:28], instr[25:0], 2'b00}.
- R8: Opcode 0 with function field (bits 5:0) equal to 8 loads the PC with rs.
- R9: link_we is 1 exactly when the opcode is 3 and stall is low. link_pc always shows PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold PC this cycle |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | 32 | Value of register rs |
| rt_val | input | 32 | Value of register rt |
| pc | output | 32 | Current program counter |
| link_pc | output | 32 | Return address PC+4 |
| link_we | output | 1 | Write link_pc into register 31 |

## Verification
A corrupted PC register shows on pc right away and then carries into every later target, because each branch target and each jump's upper four bits depend on it. A wrong target choice or a wrong branch condition shows on pc one edge after the instruction is presented. A wrong link decision shows on link_we in the same cycle. The bench therefore compares pc after every edge and link outputs before each edge.

// File: rtl/pc_steer.sv
module pc_steer #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] link_pc,
  output logic            link_we
);
  localparam logic [5:0] OP_SPEC = 6'd0, OP_BLTZ = 6'd1, OP_J = 6'd2,
                         OP_JAL = 6'd3, OP_BEQ = 6'd4, OP_BNE = 6'd5;
  localparam logic [5:0] FN_JR = 6'd8;

  logic [5:0]      opc;
  logic [XLEN-1:0] seq, br_tgt, jmp_tgt, nxt;
  logic            take_br, is_jmp, is_jr;

  assign opc     = instr[31:26];
  assign seq     = pc + XLEN'(4);
  assign br_tgt  = seq + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign jmp_tgt = {pc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign is_jmp  = (opc == OP_J) || (opc == OP_JAL);
  assign is_jr   = (opc == OP_SPEC) && (instr[5:0] == FN_JR);

  always_comb begin
    case (opc)
      OP_BLTZ: take_br = rs_val[XLEN-1];
      OP_BEQ:  take_br = (rs_val == rt_val);
      OP_BNE:  take_br = (rs_val != rt_val);
      default: take_br = 1'b0;
    endcase
  end

  always_comb begin
    if (is_jr)        nxt = rs_val;
    else if (is_jmp)  nxt = jmp_tgt;
    else if (take_br) nxt = br_tgt;
    else              nxt = seq;
  end

  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (!stall) pc <= nxt;
  end

  assign link_pc = seq;
  assign link_we = (opc == OP_JAL) && !stall;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == '0); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) stall |=> $stable(pc)); // R2
  AST_JR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr[31:26] == 6'd0 && instr[5:0] == 6'd8) |=> pc == $past(rs_val)); // R8
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (!stall && (instr[31:26] == 6'd2 || instr[31:26] == 6'd3))
      |=> pc[XLEN-1:XLEN-4] == $past(pc[XLEN-1:XLEN-4])); // R7
  AST_LINK_GATE: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (!stall && instr[31:26] == 6'd3)); // R9
  AST_NOTAKEN: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr[31:26] == 6'd4 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4); // R5
endmodule

// File: tb/test_pc_steer.sv
module test_pc_steer;
  logic clk = 0, rst = 1, stall = 0;
  logic [31:0] instr = 0, rs_val = 0, rt_val = 0;
  logic [31:0] pc, link_pc;
  logic link_we;
  int checks = 0, fails = 0;
  logic [31:0] model_pc;
  bit done = 0;

  pc_steer i_pc_steer (.clk, .rst, .stall, .instr, .rs_val, .rt_val, .pc, .link_pc, .link_we);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] ins,
                                           logic [31:0] a, logic [31:0] b);
    logic [5:0] op = ins[31:26];
    logic [31:0] s = p + 32'd4;
    logic [31:0] off = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (op == 6'd0 && ins[5:0] == 6'd8) return a;
    if (op == 6'd2 || op == 6'd3) return {p[31:28], ins[25:0], 2'b00};
    if (op == 6'd1 && a[31]) return s + off;
    if (op == 6'd4 && a == b) return s + off;
    if (op == 6'd5 && a != b) return s + off;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic st, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic [31:0] e;
    stall = st; instr = ins; rs_val = a; rt_val = b;
    #1;
    chk("R9 link_pc", link_pc, model_pc + 32'd4);
    chk("R9 link_we", {31'd0, link_we}, {31'd0, (ins[31:26] == 6'd3) && !st});
    e = st ? model_pc : exp_next(model_pc, ins, a, b);
    @(posedge clk); #2;
    model_pc = e;
    chk(req, pc, e);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; @(posedge clk); @(posedge clk); #2;
    chk("R1 reset", pc, 32'd0);
    model_pc = 0; rst = 0;
    step("R3 seq", 0, 32'h0000_0020, 0, 0);
    step("R2 stall", 1, {6'd2, 26'h3FF_FFFF}, 0, 0);
    step("R4 bltz taken", 0, {6'd1, 5'd1, 5'd7, 16'h0004}, 32'h8000_0000, 0);
    step("R4 bltz not taken rt ignored", 0, {6'd1, 10'd0, 16'h0004}, 32'h7FFF_FFFF, 32'h8000_0000);
    step("R6 beq backward", 0, {6'd4, 10'd0, 16'hFFFE}, 32'd5, 32'd5);
    step("R5 beq not taken", 0, {6'd4, 10'd0, 16'h0010}, 32'd5, 32'd6);
    step("R5 bne taken", 0, {6'd5, 10'd0, 16'h0010}, 32'd5, 32'd6);
    step("R5 bne not taken", 0, {6'd5, 10'd0, 16'h0010}, 32'd9, 32'd9);
    step("R8 jr", 0, {6'd0, 5'd31, 15'd0, 6'd8}, 32'hA000_1000, 0);
    step("R7 jal region", 0, {6'd3, 26'h000_0040}, 0, 0);
    step("R7 j", 0, {6'd2, 26'h3FF_FFFF}, 0, 0);
    step("R8 jr wrap", 0, {6'd0, 5'd2, 15'd0, 6'd8}, 32'hFFFF_FFFC, 0);
    step("R3 wrap", 0, 32'h0000_0000, 0, 0);
    step("R2 stall jal", 1, {6'd3, 26'h123}, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins = $urandom;
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom % 4 == 0) ? a : $urandom;
      logic [2:0] k = 3'($urandom % 7);
      case (k)
        3'd0: ins[31:26] = 6'd0;
        3'd1: ins[31:26] = 6'd1;
        3'd2: ins[31:26] = 6'd2;
        3'd3: ins[31:26] = 6'd3;
        3'd4: ins[31:26] = 6'd4;
        3'd5: ins[31:26] = 6'd5;
        default: ;
      endcase
      if (k == 3'd0 && ($urandom % 2 == 0)) ins[5:0] = 6'd8;
      step("R6 random", ($urandom % 8) == 0, ins, a, b);
    end
    rst = 1; @(posedge clk); #2;
    chk("R1 reset again", pc, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule